// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end and write controller of a NOR-style flash device. Bus write cycles carry an 8-bit command code in the low byte of the data word. The block decodes them, guards every change to the array behind a two-cycle sequence, and times block erase and word program with internal counters of fixed length. When an operation ends it issues a single-cycle strobe on an abstract array port. The array itself lies outside the block. The array supplies the word at the current bus address on `arr_rdata`, and the block chooses what appears on `rd_data`: array data, a status word, or identifier codes.

An erase or a program can be suspended and later resumed. While an erase is suspended, other blocks can be read and programmed. While a program is suspended, other locations can be read but no new operation may start. Three conditions protect the array. A low core supply blocks bus writes. A program-supply lock refuses or aborts operations and flags the error. An active-low write-protect pin shields the boot blocks at the bottom of the address space. The reset pin aborts everything and returns the block to array reads.

Command codes: 0xFF read array, 0x70 read status, 0x90 read identifier, 0x50 clear status, 0x20 erase setup, 0x40 program setup, 0xB0 suspend, 0xD0 confirm/resume.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst_n` is low, every operation is aborted and no array strobe occurs. After `rst_n` is released, `rd_data` returns array data and `ready` is 1.
- R2: An erase needs 0x20 followed by 0xD0; a program needs 0x40 followed by a data cycle. Once started, `ready` stays 0 for exactly ERASE_CYC or PROG_CYC running cycles. It then returns to 1 after one `arr_erase` or `arr_prog` strobe.
- R3: A program uses the address and data of its second write cycle, and an erase uses the block of its confirm cycle. Bus inputs that change later have no effect on the operation.
- R4: With `vpp_lock` high, a program or erase that would start is refused instead. A running one is aborted on the next edge. In both cases bit 0 is set together with the operation's error bit, and no array strobe occurs.
- R5: While `lowvdd` is high, bus writes are ignored: no command, setup phase or read mode changes.
- R6: The status and identifier reads work whatever the level of `vpp_lock`. Identifier mode returns MFR_ID at even addresses and DEV_ID at odd addresses.
- R7: During erase suspend, reads of other blocks return array data, and reads in the suspended block return 0. A program into another block runs normally. A program into the suspended block is refused with bit 1 set.
- R8: During program suspend, reads of other locations return array data, and the suspended location reads 0. A new setup command counts as a bad command. The counter freezes, and after 0xD0 only the remaining cycles run.
- R9: With `wp_n` low, erase or program aimed at a block whose index is below BOOT_BLOCKS is refused, setting bit 2 or bit 1 respectively. With `wp_n` high, it proceeds.
- R10: The 0xFF command returns `rd_data` to array output after an operation.
- R11: The status word is {ready, erase error, program error, supply error} in bits 3..0, with upper bits 0. 0x50 clears bits 2..0, and every setup, confirm, resume or suspend selects status output.
- R12: An undefined code, or a confirm cycle other than 0xD0, sets bits 2 and 1, selects status output and leaves the array untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous |
| lowvdd | input | 1 | Core supply below write lockout |
| vpp_lock | input | 1 | Program supply at or below lockout level |
| wp_n | input | 1 | Active-low boot-block write protect |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | AW | Bus word address |
| bus_wdata | input | DW | Bus write data, command in bits 7:0 |
| arr_rdata | input | DW | Array word at `bus_addr` |
| rd_data | output | DW | Bus read data |
| ready | output | 1 | No operation running |
| arr_prog | output | 1 | Program strobe, one cycle |
| arr_erase | output | 1 | Block erase strobe, one cycle |
| arr_addr | output | AW | Word address, or block base for erase |
| arr_wdata | output | DW | Program data |

## Verification
A wrong command phase shows up at the next bus write. A data cycle would then be taken as a command, or a command as data, and the status word or array contents read back immediately would be wrong. A counter that drifts or fails to freeze changes the number of cycles `ready` stays low, so the bench counts those cycles exactly, including after a resume. Protection and masking faults show at the ports on the very next read: an altered word, a missing error bit, or array data returned from a suspended location.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rmode_e;
  typedef enum logic [1:0] {PH_CMD, PH_ERS_CFM, PH_PRG_DATA} phase_e;
  typedef enum logic [3:0] {
    C_RDARR, C_RDSTAT, C_RDID, C_CLR, C_ERS, C_PRG, C_SUSP, C_CONFIRM, C_BAD
  } cmd_e;

  localparam logic [7:0] OP_RDARR   = 8'hFF;
  localparam logic [7:0] OP_RDSTAT  = 8'h70;
  localparam logic [7:0] OP_RDID    = 8'h90;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_ERS     = 8'h20;
  localparam logic [7:0] OP_PRG     = 8'h40;
  localparam logic [7:0] OP_SUSP    = 8'hB0;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;

  // status nibble: ready, erase error, program error, supply error
  function automatic logic [3:0] pack_status(input logic rdy, input logic ee,
                                             input logic pe, input logic ve);
    return {rdy, ee, pe, ve};
  endfunction

endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
  import fcs_pkg::*;
(
  input  logic [7:0] code,
  output cmd_e       cmd
);

  always_comb begin
    unique case (code)
      OP_RDARR:   cmd = C_RDARR;
      OP_RDSTAT:  cmd = C_RDSTAT;
      OP_RDID:    cmd = C_RDID;
      OP_CLR:     cmd = C_CLR;
      OP_ERS:     cmd = C_ERS;
      OP_PRG:     cmd = C_PRG;
      OP_SUSP:    cmd = C_SUSP;
      OP_CONFIRM: cmd = C_CONFIRM;
      default:    cmd = C_BAD;
    endcase
  end

endmodule

// File: rtl/fcs_op_timer.sv
module fcs_op_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic abort,
  output logic active,
  output logic done
);

  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign done = active && run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (abort || done) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && run) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !run && !start && !abort) |=> $stable(cnt));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run && !done && !start && !abort) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
  import fcs_pkg::*;
#(
  parameter int          DW     = 16,
  parameter logic [15:0] MFR_ID = 16'h00C2,
  parameter logic [15:0] DEV_ID = 16'h22B4
) (
  input  rmode_e        rmode,
  input  logic          busy,
  input  logic [3:0]    status,
  input  logic          odd_addr,
  input  logic          masked,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] stat_word;
  assign stat_word = {{(DW-4){1'b0}}, status};

  always_comb begin
    if (busy) begin
      rd_data = stat_word;
    end else begin
      unique case (rmode)
        RM_STATUS: rd_data = stat_word;
        RM_IDENT:  rd_data = odd_addr ? DW'(DEV_ID) : DW'(MFR_ID);
        default:   rd_data = masked ? '0 : arr_rdata;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int          AW          = 6,
  parameter int          DW          = 16,
  parameter int          BLK_BITS    = 2,
  parameter int          BOOT_BLOCKS = 1,
  parameter int          PROG_CYC    = 16,
  parameter int          ERASE_CYC   = 64,
  parameter logic [15:0] MFR_ID      = 16'h00C2,
  parameter logic [15:0] DEV_ID      = 16'h22B4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lowvdd,
  input  logic          vpp_lock,
  input  logic          wp_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  output logic          ready,
  output logic          arr_prog,
  output logic          arr_erase,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata
);

  localparam int OFS_BITS = AW - BLK_BITS;

  function automatic logic [BLK_BITS-1:0] blk_of(input logic [AW-1:0] a);
    return a[AW-1 -: BLK_BITS];
  endfunction

  function automatic logic is_boot(input logic [BLK_BITS-1:0] b);
    return int'(b) < BOOT_BLOCKS;
  endfunction

  // state
  phase_e              phase, nx_phase;
  rmode_e              rmode, nx_rmode;
  logic                ers_err, prg_err, vpp_err;
  logic                ers_susp, prg_susp;
  logic [BLK_BITS-1:0] ers_blk;
  logic [AW-1:0]       prg_addr;
  logic [DW-1:0]       prg_data;

  // named events
  cmd_e                cmd;
  logic                wr_ok, busy, boot_hit;
  logic [BLK_BITS-1:0] wr_blk;
  logic                prg_active, prg_done, prg_run, prg_abort;
  logic                ers_active, ers_done, ers_run, ers_abort, ers_go;
  logic                prg_start, ers_start, prg_refuse, ers_refuse, vpp_hit;
  logic                bad_seq, susp_ev, clr_ev, prg_resume, ers_resume;
  logic                masked;

  fcs_cmd_decode u_dec (.code(bus_wdata[7:0]), .cmd(cmd));

  assign wr_ok    = bus_we && !lowvdd;
  assign wr_blk   = blk_of(bus_addr);
  assign boot_hit = is_boot(wr_blk) && !wp_n;

  assign prg_run   = prg_active && !prg_susp && !vpp_lock;
  assign prg_abort = prg_active && !prg_susp && vpp_lock;
  assign ers_go    = ers_active && !ers_susp && !prg_active;
  assign ers_run   = ers_go && !vpp_lock;
  assign ers_abort = ers_go && vpp_lock;
  assign busy      = (prg_active && !prg_susp) || ers_go;
  assign ready     = !busy;

  fcs_op_timer #(.LEN(PROG_CYC)) u_prg_tmr (
    .clk(clk), .rst_n(rst_n), .start(prg_start), .run(prg_run),
    .abort(prg_abort), .active(prg_active), .done(prg_done)
  );

  fcs_op_timer #(.LEN(ERASE_CYC)) u_ers_tmr (
    .clk(clk), .rst_n(rst_n), .start(ers_start), .run(ers_run),
    .abort(ers_abort), .active(ers_active), .done(ers_done)
  );

  // command interpretation
  always_comb begin
    nx_phase   = phase;
    nx_rmode   = rmode;
    prg_start  = 1'b0;
    ers_start  = 1'b0;
    prg_refuse = 1'b0;
    ers_refuse = 1'b0;
    vpp_hit    = 1'b0;
    bad_seq    = 1'b0;
    susp_ev    = 1'b0;
    clr_ev     = 1'b0;
    prg_resume = 1'b0;
    ers_resume = 1'b0;
    if (wr_ok && busy) begin
      if (cmd == C_SUSP) begin
        susp_ev  = 1'b1;
        nx_rmode = RM_STATUS;
      end
    end else if (wr_ok) begin
      unique case (phase)
        PH_ERS_CFM: begin
          nx_phase = PH_CMD;
          nx_rmode = RM_STATUS;
          if (cmd != C_CONFIRM) bad_seq = 1'b1;
          else if (vpp_lock) begin
            ers_refuse = 1'b1;
            vpp_hit    = 1'b1;
          end else if (boot_hit) ers_refuse = 1'b1;
          else ers_start = 1'b1;
        end
        PH_PRG_DATA: begin
          nx_phase = PH_CMD;
          nx_rmode = RM_STATUS;
          if (vpp_lock) begin
            prg_refuse = 1'b1;
            vpp_hit    = 1'b1;
          end else if (boot_hit) prg_refuse = 1'b1;
          else if (ers_active && (wr_blk == ers_blk)) prg_refuse = 1'b1;
          else prg_start = 1'b1;
        end
        default: begin
          unique case (cmd)
            C_RDARR:  nx_rmode = RM_ARRAY;
            C_RDSTAT: nx_rmode = RM_STATUS;
            C_RDID:   nx_rmode = RM_IDENT;
            C_CLR:    clr_ev = 1'b1;
            C_SUSP:   nx_rmode = RM_STATUS;
            C_ERS: begin
              nx_rmode = RM_STATUS;
              if (ers_active || prg_active) bad_seq = 1'b1;
              else nx_phase = PH_ERS_CFM;
            end
            C_PRG: begin
              nx_rmode = RM_STATUS;
              if (prg_active) bad_seq = 1'b1;
              else nx_phase = PH_PRG_DATA;
            end
            C_CONFIRM: begin
              nx_rmode = RM_STATUS;
              if (prg_susp) prg_resume = 1'b1;
              else if (ers_susp) ers_resume = 1'b1;
              else bad_seq = 1'b1;
            end
            default: begin
              nx_rmode = RM_STATUS;
              bad_seq  = 1'b1;
            end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      rmode    <= RM_ARRAY;
      ers_err  <= 1'b0;
      prg_err  <= 1'b0;
      vpp_err  <= 1'b0;
      ers_susp <= 1'b0;
      prg_susp <= 1'b0;
      ers_blk  <= '0;
      prg_addr <= '0;
      prg_data <= '0;
    end else begin
      phase <= nx_phase;
      rmode <= nx_rmode;
      if (clr_ev) begin
        ers_err <= 1'b0;
        prg_err <= 1'b0;
        vpp_err <= 1'b0;
      end else begin
        if (bad_seq || ers_refuse || ers_abort) ers_err <= 1'b1;
        if (bad_seq || prg_refuse || prg_abort) prg_err <= 1'b1;
        if (vpp_hit || prg_abort || ers_abort)  vpp_err <= 1'b1;
      end
      if (susp_ev && prg_active && !prg_done) prg_susp <= 1'b1;
      else if (prg_resume || !prg_active)     prg_susp <= 1'b0;
      if (susp_ev && !prg_active && ers_active && !ers_done) ers_susp <= 1'b1;
      else if (ers_resume || !ers_active)                    ers_susp <= 1'b0;
      if (ers_start) ers_blk <= wr_blk;
      if (prg_start) begin
        prg_addr <= bus_addr;
        prg_data <= bus_wdata;
      end
    end
  end

  // array port
  assign arr_prog  = prg_done;
  assign arr_erase = ers_done;
  assign arr_addr  = ers_done ? {ers_blk, {OFS_BITS{1'b0}}} : prg_addr;
  assign arr_wdata = prg_data;

  // read path
  assign masked = (ers_susp && (blk_of(bus_addr) == ers_blk)) ||
                  (prg_susp && (bus_addr == prg_addr));

  fcs_read_mux #(.DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rmux (
    .rmode(rmode), .busy(busy),
    .status(pack_status(ready, ers_err, prg_err, vpp_err)),
    .odd_addr(bus_addr[0]), .masked(masked), .arr_rdata(arr_rdata),
    .rd_data(rd_data)
  );

  // R4
  vpp_noarr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_lock |-> !(arr_prog || arr_erase));

  // R5
  lowvdd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowvdd |=> ($stable(phase) && $stable(rmode)));

  // R9
  boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_start || ers_start) |-> !(is_boot(blk_of(bus_addr)) && !wp_n));

  // R7
  susp_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_start && ers_susp) |-> (blk_of(bus_addr) != ers_blk));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_start || prg_start) |=> !ready);

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_prog, arr_erase}));

endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

  localparam int AW = 6, DW = 16, BB = 2, BOOT = 1, PC = 16, EC = 64;
  localparam int NW = 1 << AW, BW = 1 << (AW - BB);
  localparam logic [15:0] MFR = 16'h00C2, DEV = 16'h22B4;

  logic clk = 1'b0, rst_n = 1'b0, lowvdd = 1'b0, vpp_lock = 1'b0, wp_n = 1'b1;
  logic bus_we = 1'b0, mem_init = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] arr_rdata, rd_data, arr_wdata;
  logic ready, arr_prog, arr_erase;
  logic [AW-1:0] arr_addr;

  logic [DW-1:0] mem [NW];
  logic [DW-1:0] exp_mem [NW];
  int n_chk = 0, n_err = 0;
  logic [DW-1:0] v;
  int n;

  always #4 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .DW(DW), .BLK_BITS(BB), .BOOT_BLOCKS(BOOT),
                  .PROG_CYC(PC), .ERASE_CYC(EC), .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .lowvdd(lowvdd), .vpp_lock(vpp_lock), .wp_n(wp_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .ready(ready), .arr_prog(arr_prog), .arr_erase(arr_erase),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  assign arr_rdata = mem[bus_addr];

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else begin
      if (arr_prog) mem[arr_addr] <= mem[arr_addr] & arr_wdata;
      if (arr_erase)
        for (int i = 0; i < BW; i++) mem[{arr_addr[AW-1 -: BB], i[AW-BB-1:0]}] <= '1;
    end
  end

  function automatic logic [15:0] st(input logic r, e, p, x);
    return {12'b0, r, e, p, x};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = ~a; bus_wdata = ~d;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_rdy(output int cnt);
    cnt = 0;
    while (ready !== 1'b1 && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) exp_mem[i] = '1;
    repeat (3) @(negedge clk);
    mem_init = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h05, v); chk("R1 array after reset", v, 16'hFFFF);
    chk("R1 ready after reset", {15'b0, ready}, 16'd1);

    // R6 R11 status and ident with supply either way
    for (int lk = 0; lk < 2; lk++) begin
      vpp_lock = lk[0];
      wr(0, 16'h0070); rd(0, v); chk("R11 idle status", v, st(1,0,0,0));
      wr(0, 16'h0090);
      rd(6'h00, v); chk("R6 maker id", v, MFR);
      rd(6'h01, v); chk("R6 device id", v, DEV);
    end
    vpp_lock = 1'b0;

    // R2 R3 R10 program with address from data cycle
    wr(6'h30, 16'h0040); wr(6'h22, 16'h1234);
    exp_mem[6'h22] &= 16'h1234;
    wait_rdy(n); chk("R2 program busy cycles", 16'(n), 16'(PC));
    rd(0, v); chk("R11 status after program", v, st(1,0,0,0));
    wr(0, 16'h00FF);
    rd(6'h22, v); chk("R3 R10 programmed word", v, exp_mem[6'h22]);
    rd(6'h30, v); chk("R3 setup address untouched", v, exp_mem[6'h30]);

    // R2 erase block 2
    wr(6'h20, 16'h0020); wr(6'h25, 16'h00D0);
    wait_rdy(n); chk("R2 erase busy cycles", 16'(n), 16'(EC));
    for (int i = 0; i < BW; i++) exp_mem[32 + i] = '1;
    wr(0, 16'h00FF);
    for (int i = 0; i < BW; i++) begin
      rd(6'(32 + i), v); chk("R2 erased word", v, 16'hFFFF);
    end

    // R12 undefined codes
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hFF || c == 8'h70 || c == 8'h90 || c == 8'h50 ||
          c == 8'h20 || c == 8'h40 || c == 8'hB0 || c == 8'hD0) continue;
      wr(0, 16'(c)); rd(0, v); chk("R12 undefined code", v, st(1,1,1,0));
      wr(0, 16'h0050); rd(0, v); chk("R11 clear status", v, st(1,0,0,0));
    end

    // R12 bad confirm
    wr(6'h10, 16'h0020); wr(6'h10, 16'h0040);
    rd(0, v); chk("R12 bad confirm", v, st(1,1,1,0));
    wr(0, 16'h0050); wr(0, 16'h00FF);
    rd(6'h10, v); chk("R12 array untouched", v, exp_mem[6'h10]);

    // R9 protect sweep
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 4; b++) begin
        logic ok;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        wp_n = w[0];
        ok = !(b < BOOT && w == 0);
        a = 6'(b * BW + 3 + w);
        d = 16'hA5A5 ^ 16'((b << 4) | w);
        wr(a, 16'h0040); wr(a, d);
        if (ok) begin
          exp_mem[a] &= d;
          wait_rdy(n); chk("R9 program busy", 16'(n), 16'(PC));
        end
        rd(0, v); chk("R9 program status", v, ok ? st(1,0,0,0) : st(1,0,1,0));
        wr(0, 16'h0050);
        wr(0, 16'h00FF);
        rd(a, v); chk("R9 program word", v, exp_mem[a]);
        wr(6'(b * BW), 16'h0020); wr(6'(b * BW), 16'h00D0);
        if (ok) begin
          for (int i = 0; i < BW; i++) exp_mem[b * BW + i] = '1;
          wait_rdy(n); chk("R9 erase busy", 16'(n), 16'(EC));
        end
        rd(0, v); chk("R9 erase status", v, ok ? st(1,0,0,0) : st(1,1,0,0));
        wr(0, 16'h0050); wr(0, 16'h00FF);
        rd(a, v); chk("R9 word after erase", v, exp_mem[a]);
      end
    end
    wp_n = 1'b1;

    // R4 supply lock refusal and abort
    vpp_lock = 1'b1;
    rd(0, v); chk("R6 array read under lock", v, exp_mem[0]);
    wr(6'h31, 16'h0040); wr(6'h31, 16'h0000);
    rd(0, v); chk("R4 program refused", v, st(1,0,1,1));
    wr(0, 16'h0050);
    wr(6'h30, 16'h0020); wr(6'h30, 16'h00D0);
    rd(0, v); chk("R4 erase refused", v, st(1,1,0,1));
    wr(0, 16'h0050);
    vpp_lock = 1'b0;
    wr(6'h32, 16'h0040); wr(6'h32, 16'h0000);
    repeat (3) @(negedge clk);
    vpp_lock = 1'b1;
    @(negedge clk);
    chk("R4 abort ready", {15'b0, ready}, 16'd1);
    rd(0, v); chk("R4 abort status", v, st(1,0,1,1));
    vpp_lock = 1'b0;
    wr(0, 16'h0050); wr(0, 16'h00FF);
    rd(6'h31, v); chk("R4 word kept", v, exp_mem[6'h31]);
    rd(6'h32, v); chk("R4 aborted word kept", v, exp_mem[6'h32]);

    // R5 low supply ignores writes
    lowvdd = 1'b1;
    wr(6'h33, 16'h0040); wr(6'h33, 16'h0000); wr(0, 16'h0070);
    lowvdd = 1'b0;
    rd(6'h33, v); chk("R5 still array mode", v, exp_mem[6'h33]);
    wr(6'h33, 16'h0070);
    rd(0, v); chk("R5 no pending setup", v, st(1,0,0,0));
    wr(0, 16'h00FF);
    rd(6'h33, v); chk("R5 word unchanged", v, exp_mem[6'h33]);

    // R1 reset during erase
    wr(6'h2A, 16'h0040); wr(6'h2A, 16'h0000);
    exp_mem[6'h2A] = '0;
    wait_rdy(n);
    wr(6'h20, 16'h0020); wr(6'h20, 16'h00D0);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after abort", {15'b0, ready}, 16'd1);
    rd(6'h2A, v); chk("R1 array mode, block unchanged", v, 16'h0000);

    // R7 erase suspend
    wr(6'h10, 16'h0020); wr(6'h10, 16'h00D0);
    repeat (10) @(negedge clk);
    wr(0, 16'h00B0);
    chk("R7 ready in suspend", {15'b0, ready}, 16'd1);
    rd(0, v); chk("R11 status in suspend", v, st(1,0,0,0));
    wr(0, 16'h00FF);
    rd(6'h2A, v); chk("R7 other block read", v, exp_mem[6'h2A]);
    rd(6'h15, v); chk("R7 suspended block masked", v, 16'h0000);
    wr(6'h15, 16'h0040); wr(6'h15, 16'h1111);
    rd(0, v); chk("R7 program into suspended block", v, st(1,0,1,0));
    wr(0, 16'h0050);
    wr(6'h3C, 16'h0040); wr(6'h3C, 16'h0F0F);
    exp_mem[6'h3C] &= 16'h0F0F;
    wait_rdy(n); chk("R7 nested program busy", 16'(n), 16'(PC));
    wr(0, 16'h00FF);
    rd(6'h3C, v); chk("R7 nested program word", v, exp_mem[6'h3C]);
    wr(0, 16'h00D0);
    for (int i = 0; i < BW; i++) exp_mem[16 + i] = '1;
    wait_rdy(n); chk("R7 remaining erase cycles", 16'(n), 16'(EC - 11));
    wr(0, 16'h00FF);
    rd(6'h15, v); chk("R7 erased after resume", v, 16'hFFFF);

    // R8 program suspend
    wr(6'h0E, 16'h0040); wr(6'h0E, 16'h00F0);
    repeat (4) @(negedge clk);
    wr(0, 16'h00B0);
    chk("R8 ready in suspend", {15'b0, ready}, 16'd1);
    wr(0, 16'h00FF);
    rd(6'h0E, v); chk("R8 suspended word masked", v, 16'h0000);
    rd(6'h3C, v); chk("R8 other word read", v, exp_mem[6'h3C]);
    wr(0, 16'h0020);
    rd(0, v); chk("R8 setup refused", v, st(1,1,1,0));
    wr(0, 16'h0050);
    wr(0, 16'h00D0);
    exp_mem[6'h0E] &= 16'h00F0;
    wait_rdy(n); chk("R8 remaining program cycles", 16'(n), 16'(PC - 5));
    wr(0, 16'h00FF);
    rd(6'h0E, v); chk("R8 R10 word after resume", v, exp_mem[6'h0E]);

    summary();
    $finish;
  end

endmodule